// File: doc/BRIEF.md
# Half-integer clock divider branch

This block is one branch of a clock tree. It divides a source clock by 1.5, 2.5, 3.5 and so on. An optional source multiplexer sits first in the path, then an optional clock gate, then the divider. The output frequency is `2*f_in/(2N+3)`, where N is an unsigned field of parameterised width and offset. The divider counts half-periods of the selected source, so it acts on both edges of that clock. Each output period spans 2N+3 half-periods: N+1 high, then N+2 low.

Software configures the branch through a small synchronous register port with two 32-bit registers. Address 0 holds the divider field and the source-select field. Address 1 holds a single run-enable bit for the gate. When the write-mask parameter is set, bit `k+16` of a write enables the update of stored bit `k`. A driver can therefore change one field without first reading the register.

A new N is captured only where an output period begins, so a ratio change never produces a short pulse. When the gate is turned off, the output finishes any high phase in progress and then stays low. When the gate is turned on again, the output starts a fresh period.

Top module: `half_div_branch`

## Requirements
- R1: The output repeats every 2N+3 half-periods of the selected source. Each period is high for N+1 half-periods and then low for N+2, so N=0 divides by 1.5.
- R2: N is an unsigned field of width `N_W` at bit offset `N_OFS` in register 0. Every value from 0 to 2^N_W-1 gives the ratio of R1, including the largest.
- R3: With `HIWORD=1`, a write changes stored bit k only when write-data bit k+16 is 1. A write whose enable bits are all 0 leaves the register unchanged.
- R4: With `HIWORD=0`, a write to register 0 loads every stored field of that register from the write data, and the upper half of the write data is ignored.
- R5: A new N takes effect only at the start of an output period. Every output period is made entirely under either the old N or the new N, and no output pulse is shorter than one source half-period.
- R6: Clearing the run bit (register 1, bit `GATE_BIT`, 1 = run) stops the output low, but only after any high phase in progress has lasted its full N+1 half-periods. Setting the bit again starts a fresh period that begins with a full high phase.
- R7: The select field (`SEL_OFS`, 0 = source 0, 1 = source 1) chooses which source the divider counts. The multiplexer exists only when `NUM_SRC` > 1.
- R8: While reset is held and after it is released, N is 0, the select field is 0 and the run bit is 1. The output is low while reset is held.
- R9: A read returns the stored fields at their own bit positions. The upper 16 bits and all other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | NUM_SRC | Candidate source clocks |
| rst_n | input | 1 | Synchronous active-low reset, held across several edges of each clock |
| cfg_clk | input | 1 | Clock of the register port |
| cfg_we | input | 1 | Write strobe |
| cfg_addr | input | 1 | Register select: 0 divider/select, 1 run enable |
| cfg_wdata | input | 32 | Write data, with the enable mask in the upper half |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that reset is held long enough for both the register clock and the selected source to see it. They also assume that the source select changes only while the branch is parked by its run bit, because the multiplexer itself has no glitch protection. The bench keeps to these rules: it holds reset for a dozen register cycles, and it always clears the run bit and waits before it changes the source. The N field is written while the divider is running, and at arbitrary phases, because capture at the period boundary is the behaviour under test.

// File: rtl/hdiv_pkg.sv
// Package: shared constants and register addresses of the half-integer
// divider branch. Assumes a 32-bit register port whose upper half carries
// the per-bit write enables.
package hdiv_pkg;
    localparam int REG_W   = 32;
    localparam int MASK_SH = 16;

    typedef enum logic {
        ADDR_DIV  = 1'b0,
        ADDR_GATE = 1'b1
    } hdiv_addr_e;
endpackage

// File: rtl/hdiv_cfg_regs.sv
// Module: configuration registers. Register 0 holds the divider field and
// the source-select field; register 1 holds the run-enable bit. Assumes that
// every field lies in the lower 16 bits and that no two fields overlap.
module hdiv_cfg_regs
    import hdiv_pkg::*;
#(
    parameter int N_W      = 3,
    parameter int N_OFS    = 0,
    parameter int SEL_W    = 1,
    parameter int SEL_OFS  = 8,
    parameter int HAS_MUX  = 1,
    parameter int HAS_GATE = 1,
    parameter int GATE_BIT = 2,
    parameter int HIWORD   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [N_W-1:0]   n_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             gate_q
);
    localparam int N_EN_OFS    = N_OFS + MASK_SH;
    localparam int SEL_EN_OFS  = SEL_OFS + MASK_SH;
    localparam int GATE_EN_OFS = GATE_BIT + MASK_SH;

    logic           div_wr;
    logic           gate_wr;
    logic [N_W-1:0] n_en;
    logic           unused_wdata;

    assign div_wr       = we && (addr == ADDR_DIV);
    assign gate_wr      = we && (addr == ADDR_GATE);
    assign n_en         = (HIWORD != 0) ? wdata[N_EN_OFS +: N_W] : '1;
    assign unused_wdata = ^wdata;

    // Divider field: per-bit masked or whole-field update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            n_q <= '0;
        else if (div_wr)
            n_q <= (n_q & ~n_en) | (wdata[N_OFS +: N_W] & n_en);
    end

    generate
        if (HAS_MUX != 0) begin : g_sel
            logic [SEL_W-1:0] sel_en;
            assign sel_en = (HIWORD != 0) ? wdata[SEL_EN_OFS +: SEL_W] : '1;
            // Source select field shares register 0 with the divider field.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sel_q <= '0;
                else if (div_wr)
                    sel_q <= (sel_q & ~sel_en) | (wdata[SEL_OFS +: SEL_W] & sel_en);
            end
        end else begin : g_nosel
            assign sel_q = '0;
        end

        if (HAS_GATE != 0) begin : g_gate
            logic gate_en;
            assign gate_en = (HIWORD != 0) ? wdata[GATE_EN_OFS] : 1'b1;
            // Run-enable bit in register 1; resets to running.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    gate_q <= 1'b1;
                else if (gate_wr && gate_en)
                    gate_q <= wdata[GATE_BIT];
            end
        end else begin : g_nogate
            assign gate_q = 1'b1;
        end
    endgenerate

    // Read mux: stored fields only, everything else zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_DIV) begin
            rdata[N_OFS +: N_W] = n_q;
            if (HAS_MUX != 0)
                rdata[SEL_OFS +: SEL_W] = sel_q;
        end else if (HAS_GATE != 0) begin
            rdata[GATE_BIT] = gate_q;
        end
    end

    generate
        if (HIWORD != 0) begin : g_chk_mask
            assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (div_wr && (wdata[N_EN_OFS +: N_W] == '0)) |=> $stable(n_q));
        end else begin : g_chk_full
            assert_full_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
                div_wr |=> (n_q == $past(wdata[N_OFS +: N_W])));
        end
    endgenerate
endmodule

// File: rtl/hdiv_src_select.sv
// Module: source clock multiplexer. Picks one of NUM_SRC clocks by the select
// field. Assumes the select changes only while the branch is parked, since
// this mux has no glitch protection of its own.
module hdiv_src_select #(
    parameter int NUM_SRC = 2,
    parameter int SEL_W   = 1,
    parameter int HAS_MUX = 1
) (
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_sel
);
    generate
        if (HAS_MUX != 0) begin : g_mux
            // Out-of-range selects fall back to source 0.
            assign clk_sel = (32'(sel) < NUM_SRC) ? src_clk[sel] : src_clk[0];
        end else begin : g_direct
            logic unused_sel;
            assign unused_sel = ^sel;
            assign clk_sel    = src_clk[0];
        end
    endgenerate
endmodule

// File: rtl/hdiv_core.sv
// Module: half-period divider core. At each rising edge it works out the
// output level for the two half-periods that follow. It emits them through
// a rising-edge toggle flop and a falling-edge toggle flop whose XOR is the
// output, so only one input of the XOR changes at any edge. N is captured
// only at position 0 of a period. Assumes n_cfg is quasi-static relative
// to clk.
module hdiv_core #(
    parameter int N_W      = 3,
    parameter int HAS_GATE = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_W-1:0] n_cfg,
    input  logic           gate_req,
    output logic           clk_out
);
    localparam int P_W = N_W + 2;

    logic [P_W-1:0] p_q, x1, x2;
    logic [N_W-1:0] n_act, n0, n1;
    logic           park0, park1, a_lvl, b_lvl;
    logic           r_q, f_q, b_hold, tgl_q;
    logic           gate_on;

    function automatic logic [P_W-1:0] last_pos(input logic [N_W-1:0] n);
        return {1'b0, n, 1'b0} + P_W'(2);
    endfunction

    generate
        if (HAS_GATE != 0) begin : g_gsync
            logic [1:0] sync_q;
            // Two-stage synchroniser for the run-enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= 2'b11;
                else        sync_q <= {sync_q[0], gate_req};
            end
            assign gate_on = sync_q[1];
        end else begin : g_nogate
            logic unused_gate;
            assign unused_gate = gate_req;
            assign gate_on     = 1'b1;
        end
    endgenerate

    // Step two half-periods: reload N at position 0, park when stopped.
    always_comb begin
        n0    = (p_q == '0) ? n_cfg : n_act;
        park0 = !gate_on && ((p_q == '0) || (p_q > {2'b00, n0}));
        a_lvl = !park0 && (p_q <= {2'b00, n0});
        if (park0 || (p_q == last_pos(n0))) x1 = '0;
        else                                x1 = p_q + P_W'(1);

        n1    = (x1 == '0) ? n_cfg : n0;
        park1 = !gate_on && ((x1 == '0) || (x1 > {2'b00, n1}));
        b_lvl = !park1 && (x1 <= {2'b00, n1});
        if (park1 || (x1 == last_pos(n1))) x2 = '0;
        else                               x2 = x1 + P_W'(1);
    end

    // Rising-edge state: position, active N, rising toggle, falling plan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q    <= '0;
            n_act  <= '0;
            r_q    <= 1'b0;
            b_hold <= 1'b0;
            tgl_q  <= 1'b0;
        end else begin
            p_q    <= x2;
            n_act  <= n1;
            r_q    <= r_q ^ a_lvl ^ b_hold;
            b_hold <= b_lvl;
            tgl_q  <= a_lvl ^ b_lvl;
        end
    end

    // Falling-edge toggle moves the output to the second half's level.
    always_ff @(negedge clk) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= f_q ^ tgl_q;
    end

    assign clk_out = r_q ^ f_q;

    assert_pos_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        p_q <= last_pos(n_act));

    assert_n_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on && (p_q != '0) && (p_q != last_pos(n_act))) |=> $stable(n_act));

    assert_park_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_on && (p_q == '0)) |=> ((p_q == '0) && !(r_q ^ f_q)));

    assert_high_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_on && (p_q != '0) && (p_q <= {2'b00, n_act})) |-> a_lvl);
endmodule

// File: rtl/half_div_branch.sv
// Module: top of the clock branch. Path order is source mux, then gate,
// then half-integer divider. Assumes that rst_n is held across several
// edges of cfg_clk and of the selected source.
module half_div_branch
    import hdiv_pkg::*;
#(
    parameter int NUM_SRC  = 2,
    parameter int N_W      = 3,
    parameter int N_OFS    = 0,
    parameter int SEL_OFS  = 8,
    parameter int HAS_GATE = 1,
    parameter int GATE_BIT = 2,
    parameter int HIWORD   = 1
) (
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               rst_n,
    input  logic               cfg_clk,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    output logic               clk_out
);
    localparam int HAS_MUX = (NUM_SRC > 1) ? 1 : 0;
    localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [N_W-1:0]   n_q;
    logic [SEL_W-1:0] sel_q;
    logic             gate_q;
    logic             clk_sel;

    hdiv_cfg_regs #(
        .N_W(N_W), .N_OFS(N_OFS), .SEL_W(SEL_W), .SEL_OFS(SEL_OFS),
        .HAS_MUX(HAS_MUX), .HAS_GATE(HAS_GATE), .GATE_BIT(GATE_BIT),
        .HIWORD(HIWORD)
    ) u_regs (
        .clk(cfg_clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .n_q(n_q), .sel_q(sel_q), .gate_q(gate_q)
    );

    hdiv_src_select #(
        .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .HAS_MUX(HAS_MUX)
    ) u_sel (
        .src_clk(src_clk), .sel(sel_q), .clk_sel(clk_sel)
    );

    hdiv_core #(
        .N_W(N_W), .HAS_GATE(HAS_GATE)
    ) u_core (
        .clk(clk_sel), .rst_n(rst_n), .n_cfg(n_q),
        .gate_req(gate_q), .clk_out(clk_out)
    );
endmodule

// File: tb/half_div_branch_test.sv
// Scoreboard bench: driver tasks queue expected (high, low) run lengths in
// source half-periods; a monitor measures the output and pops and compares.
module half_div_branch_test;
    logic [1:0]  src_clk = 2'b00;
    logic        cfg_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_we_raw = 1'b0, cfg_addr = 1'b0;
    logic [31:0] cfg_wdata = '0, rdata, rdata_raw, rv;
    logic        clk_out, clk_out_raw;

    always #5  cfg_clk    = ~cfg_clk;
    always #20 src_clk[0] = ~src_clk[0];
    always #15 src_clk[1] = ~src_clk[1];

    half_div_branch uut (.src_clk(src_clk), .rst_n(rst_n), .cfg_clk(cfg_clk),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rdata), .clk_out(clk_out));
    half_div_branch #(.HIWORD(0)) uut_raw (.src_clk(src_clk), .rst_n(rst_n),
        .cfg_clk(cfg_clk), .cfg_we(cfg_we_raw), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_raw), .clk_out(clk_out_raw));

    int n_chk = 0, n_fail = 0;
    int exp_hi[$], exp_lo[$];
    int mode = 0;           // 0 ignore, 1 queue, 2 old/new set
    string mtag = "R1";
    int set_a = 0, set_b = 0, set_pairs = 0;
    bit mon_on = 0, mon_sel = 0;
    logic mon_clk;
    assign mon_clk = mon_sel ? src_clk[1] : src_clk[0];

    task automatic chk(string tag, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: run lengths of clk_out counted in source half-periods.
    int run_len = 0, hi_len = 0;
    bit cur = 0, hi_ok = 0;
    always @(mon_clk) begin
        if (mon_on) begin
            #1;
            if (clk_out === cur) run_len++;
            else begin
                if (cur) begin hi_len = run_len; hi_ok = 1; end
                else if (hi_ok) begin
                    if (mode == 1 && exp_hi.size() > 0) begin
                        int eh, el;
                        eh = exp_hi.pop_front(); el = exp_lo.pop_front();
                        chk({mtag, " high"}, hi_len == eh, hi_len, eh);
                        chk({mtag, " low"}, run_len == el, run_len, el);
                    end else if (mode == 2) begin
                        set_pairs++;
                        chk("R5 period", (hi_len == set_a + 1 && run_len == set_a + 2) ||
                            (hi_len == set_b + 1 && run_len == set_b + 2),
                            hi_len * 100 + run_len, (set_a + 1) * 100 + set_a + 2);
                    end
                end
                cur = clk_out; run_len = 1;
            end
        end
    end

    // Time monitor: pulse widths in ns, plus the rising-edge count.
    time last_t = 0, last_hi_w = 0, min_w = 0;
    bit  tmin_on = 0;
    int  rise_cnt = 0;
    always @(clk_out) begin
        if (mon_on) begin
            if (clk_out === 1'b0) last_hi_w = $time - last_t;
            if (tmin_on && ($time - last_t) < min_w) min_w = $time - last_t;
            last_t = $time;
        end
    end
    always @(posedge clk_out) rise_cnt++;

    task automatic wr(input bit raw, input logic a, input logic [31:0] d);
        @(negedge cfg_clk);
        cfg_addr = a; cfg_wdata = d;
        if (raw) cfg_we_raw = 1; else cfg_we = 1;
        @(negedge cfg_clk);
        cfg_we = 0; cfg_we_raw = 0;
    endtask

    task automatic rd(input bit raw, input logic a, output logic [31:0] d);
        @(negedge cfg_clk);
        cfg_addr = a; #1;
        d = raw ? rdata_raw : rdata;
    endtask

    task automatic push(input int hi, input int lo, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            exp_hi.push_back(hi); exp_lo.push_back(lo);
        end
    endtask

    task automatic drain;
        while (exp_hi.size() != 0) @(posedge cfg_clk);
        mode = 0;
    endtask

    initial begin
        repeat (150000) @(posedge cfg_clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (12) @(posedge cfg_clk);
        #1 chk("R8 output low in reset", clk_out === 1'b0, int'(clk_out), 0);
        @(negedge cfg_clk); rst_n = 1; mon_on = 1;

        rd(0, 0, rv); chk("R8 reg0 reset", rv == 32'h0, rv, 0);
        rd(0, 1, rv); chk("R8 reg1 reset run=1", rv == 32'h4, rv, 4);
        rd(1, 0, rv); chk("R8 raw reg0 reset", rv == 32'h0, rv, 0);

        // R1/R2: sweep every N of the 3-bit field, enables at bits 18:16.
        for (int n = 0; n < 8; n++) begin
            mode = 0;
            wr(0, 0, 32'h0007_0000 | n);
            rd(0, 0, rv); chk("R9 readback N", rv == n, rv, n);
            repeat (40) @(posedge src_clk[0]);
            mtag = (n == 7) ? "R2" : "R1";
            push(n + 1, n + 2, 4);
            mode = 1;
            drain();
        end

        // R3: masked writes.
        wr(0, 0, 32'h0000_0102);
        rd(0, 0, rv); chk("R3 no enables keeps reg", rv == 32'h7, rv, 7);
        wr(0, 0, 32'h0002_0000);
        rd(0, 0, rv); chk("R3 only bit1 cleared", rv == 32'h5, rv, 5);
        wr(0, 0, 32'hFFFF_0003);
        rd(0, 0, rv); chk("R9 upper half reads zero", rv == 32'h3, rv, 3);
        rd(0, 1, rv); chk("R9 run bit read", rv == 32'h4, rv, 4);

        // R4: unmasked instance loads all fields.
        wr(1, 0, 32'h0000_0105);
        rd(1, 0, rv); chk("R4 full load", rv == 32'h105, rv, 32'h105);
        wr(1, 0, 32'h0003_0002);
        rd(1, 0, rv); chk("R4 sel replaced, mask ignored", rv == 32'h2, rv, 2);

        // R5: ratio changes while running, between N=2 and N=5.
        wr(0, 0, 32'h0007_0002);
        repeat (40) @(posedge src_clk[0]);
        set_a = 2; set_b = 5; set_pairs = 0;
        min_w = 1000000; tmin_on = 1; mode = 2;
        for (int k = 0; k < 6; k++) begin
            wr(0, 0, 32'h0007_0005);
            repeat (k + 3) @(posedge src_clk[0]);
            wr(0, 0, 32'h0007_0002);
            repeat (k + 2) @(posedge src_clk[0]);
        end
        repeat (30) @(posedge src_clk[0]);
        mode = 0; tmin_on = 0;
        chk("R5 no runt pulse (ns)", min_w >= 20, int'(min_w), 20);
        chk("R5 periods observed", set_pairs >= 5, set_pairs, 5);

        // R6: gate off mid-high, then restart.
        wr(0, 0, 32'h0007_0003);
        repeat (30) @(posedge src_clk[0]);
        @(posedge clk_out); #30;
        wr(0, 1, 32'h0004_0000);
        repeat (10) @(posedge src_clk[0]);
        chk("R6 last high full width (ns)", last_hi_w == 80, int'(last_hi_w), 80);
        begin
            int snap;
            snap = rise_cnt;
            repeat (20) @(posedge src_clk[0]);
            chk("R6 no pulses while stopped", rise_cnt == snap, rise_cnt, snap);
            #1 chk("R6 parked low", clk_out === 1'b0, int'(clk_out), 0);
        end
        wr(0, 1, 32'h0004_0004);
        @(posedge clk_out); #2;
        mtag = "R6"; push(4, 5, 2); mode = 1;
        @(negedge clk_out); #1;
        chk("R6 fresh first high (ns)", last_hi_w == 80, int'(last_hi_w), 80);
        drain();

        // R7: park, select source 1 (bit 8, enable bit 24) with N=1, restart.
        wr(0, 1, 32'h0004_0000);
        repeat (30) @(posedge src_clk[0]);
        wr(0, 0, 32'h0107_0101);
        mon_sel = 1;
        rd(0, 0, rv); chk("R7 select readback", rv == 32'h101, rv, 32'h101);
        wr(0, 1, 32'h0004_0004);
        @(posedge clk_out); #2;
        mtag = "R7"; push(2, 3, 3); mode = 1;
        @(negedge clk_out); #1;
        chk("R7 high uses source 1 (ns)", last_hi_w == 30, int'(last_hi_w), 30);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule